// File: doc/BRIEF.md
# Multi-Mode Serial Line Encoder

This block turns a serial stream of data bits into a line signal in one of six codes: two level codes (NRZ-L and NRZI), two biphase codes (Manchester and differential Manchester), and two three-level codes (bipolar AMI and pseudoternary). A single datapath serves all six. It keeps a binary level register for the level and biphase codes, and a mark-polarity register for the three-level codes. A phase flag tracks whether the next timing tick opens a bit or falls in its middle.

Timing comes from `half_tick`, a one-cycle strobe that fires twice per bit period. The ticks alternate between the start of a bit and its middle, and the first tick after reset is a start tick. Input bits use a valid/ready handshake. `in_ready` is high only during a start tick, and a bit transfers in that cycle when `in_valid` is also high. A source that holds `in_valid` high simply waits until the next start tick, and its bit stays on the input until the transfer. If a start tick passes with no valid bit, that bit period is an idle slot. An idle slot is also the only point where a new mode is taken from `mode_i`. The output is registered, and it changes only in the cycle after a tick.

Top module: `line_encoder`

## Requirements
- R1: While reset is asserted and just after it, `line_o` is 2'b11 (lower) and `in_ready` is 0. The binary level starts low, the mode starts at 0 (NRZ-L), and the first mark in a three-level code after reset uses the upper level.
- R2: `in_ready` is 1 only in a cycle where `half_tick` is high and the tick is a bit-start tick. Ticks alternate between start and middle, and the first tick after reset is a start tick. A bit transfers when `in_valid` and `in_ready` are both high.
- R3: In mode 0 (NRZ-L), line code 2'b01 (upper) is high and 2'b11 (lower) is low. The line is high for a 1 and low for a 0 for the whole bit. Modes 6 and 7 behave as mode 0. Binary modes never drive 2'b00.
- R4: In mode 1 (NRZI), a 1 inverts the level at the start of the bit and a 0 keeps it. The level holds through the middle of the bit.
- R5: In mode 2 (Manchester), a 1 is high in the first half and low in the second. A 0 is low in the first half and high in the second.
- R6: In mode 3 (differential Manchester), the level always inverts at mid-bit. At the start of the bit, a 0 also inverts it and a 1 keeps it.
- R7: In mode 4 (bipolar AMI), a 0 drives 2'b00 (middle). Each 1 drives the upper level (2'b01) or the lower level (2'b11), the opposite of the previous mark. The level is held for the whole bit.
- R8: In mode 5 (pseudoternary), a 1 drives the middle level and each 0 is a mark. Marks alternate upper and lower, and mode 5 shares its polarity history with mode 4.
- R9: In an idle slot, the binary and biphase modes keep the present level for the whole bit, and the three-level modes drive the middle level.
- R10: `mode_i` is sampled only at a start tick with no valid bit. Its value has no effect while bits are being transferred.
- R11: `line_o` changes only in the cycle after a `half_tick`, and it never shows 2'b10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| half_tick | input | 1 | One-cycle strobe, two per bit period |
| mode_i | input | 3 | Requested line code, taken in idle slots |
| in_valid | input | 1 | Input bit is valid |
| in_ready | output | 1 | Encoder takes a bit this cycle |
| in_bit | input | 1 | Data bit |
| line_o | output | 2 | Line code: 01 upper, 00 middle, 11 lower |

## Verification
A corrupted binary level shows up at once in NRZ-L and Manchester, because the next half-bit carries the wrong code. In NRZI and differential Manchester the same error inverts every later half-bit until the next reset, so one bad half-bit is enough to break the whole rest of the stream. A wrong mark polarity makes two marks in a row share a level in AMI or pseudoternary, and the next mark exposes it. A phase flag that drifts swaps start and mid ticks: `in_ready` then appears on a mid tick, and the biphase halves come out in the wrong order within one bit period.

// File: rtl/lenc_pkg.sv
package lenc_pkg;
  localparam int MODE_W = 3;
  localparam int CODE_W = 2;

  localparam logic [MODE_W-1:0] MD_NRZL = 3'd0;
  localparam logic [MODE_W-1:0] MD_NRZI = 3'd1;
  localparam logic [MODE_W-1:0] MD_MAN  = 3'd2;
  localparam logic [MODE_W-1:0] MD_DMAN = 3'd3;
  localparam logic [MODE_W-1:0] MD_AMI  = 3'd4;
  localparam logic [MODE_W-1:0] MD_PST  = 3'd5;

  localparam logic [CODE_W-1:0] LC_HI  = 2'b01;
  localparam logic [CODE_W-1:0] LC_MID = 2'b00;
  localparam logic [CODE_W-1:0] LC_LO  = 2'b11;

  function automatic logic is_tern(input logic [MODE_W-1:0] m);
    return (m == MD_AMI) || (m == MD_PST);
  endfunction
endpackage

// File: rtl/lenc_phase.sv
module lenc_phase (
  input  logic clk,
  input  logic rst_n,
  input  logic half_tick,
  input  logic in_valid,
  input  logic in_bit,
  output logic in_ready,
  output logic take,
  output logic idle_slot,
  output logic mid_go,
  output logic bit_q
);
  logic phase_q;   // 0: next tick opens a bit, 1: next tick is mid-bit
  logic loaded_q;  // a bit occupies the current period

  assign in_ready  = half_tick & ~phase_q;
  assign take      = in_ready & in_valid;
  assign idle_slot = in_ready & ~in_valid;
  assign mid_go    = half_tick & phase_q & loaded_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= 1'b0;
      loaded_q <= 1'b0;
      bit_q    <= 1'b0;
    end else begin
      if (half_tick) phase_q <= ~phase_q;
      if (in_ready) loaded_q <= in_valid;
      if (take) bit_q <= in_bit;
    end
  end

  p_phase_alt_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (half_tick && !phase_q) |=> phase_q);
  p_phase_back_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (half_tick && phase_q) |=> !phase_q);
endmodule

// File: rtl/lenc_binary.sv
module lenc_binary
  import lenc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [MODE_W-1:0] mode,
  input  logic              take,
  input  logic              in_bit,
  input  logic              mid_go,
  output logic              lvl_q
);
  logic lvl_d;

  always_comb begin
    lvl_d = lvl_q;
    if (en && take) begin
      unique case (mode)
        MD_NRZI: lvl_d = lvl_q ^ in_bit;
        MD_MAN:  lvl_d = in_bit;
        MD_DMAN: lvl_d = in_bit ? lvl_q : ~lvl_q;
        default: lvl_d = in_bit;
      endcase
    end else if (en && mid_go && (mode == MD_MAN || mode == MD_DMAN)) begin
      lvl_d = ~lvl_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl_d;
  end

  p_dman_mid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && mid_go && mode == MD_DMAN) |=> (lvl_q != $past(lvl_q)));
  p_nrzi_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && take && mode == MD_NRZI && !in_bit) |=> $stable(lvl_q));
endmodule

// File: rtl/lenc_ternary.sv
module lenc_ternary
  import lenc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [MODE_W-1:0] mode,
  input  logic              take,
  input  logic              idle_slot,
  input  logic              in_bit,
  output logic [CODE_W-1:0] code_q
);
  logic pol_q;  // 0: next mark upper, 1: next mark lower
  logic mark;

  assign mark = (mode == MD_PST) ? ~in_bit : in_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q  <= 1'b0;
      code_q <= LC_MID;
    end else if (en && take) begin
      if (mark) begin
        code_q <= pol_q ? LC_LO : LC_HI;
        pol_q  <= ~pol_q;
      end else begin
        code_q <= LC_MID;
      end
    end else if (idle_slot) begin
      code_q <= LC_MID;
    end
  end

  p_pol_flip_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && take && mark) |=> (pol_q != $past(pol_q)));
  p_space_mid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && take && !mark) |=> (code_q == LC_MID));
endmodule

// File: rtl/line_encoder.sv
module line_encoder
  import lenc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              half_tick,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_bit,
  output logic [CODE_W-1:0] line_o
);
  logic [MODE_W-1:0] mode_q;
  logic              take, idle_slot, mid_go, bit_q;
  logic              lvl_q;
  logic [CODE_W-1:0] tcode_q;
  logic              tern;

  lenc_phase u_phase (
    .clk(clk), .rst_n(rst_n), .half_tick(half_tick), .in_valid(in_valid),
    .in_bit(in_bit), .in_ready(in_ready), .take(take), .idle_slot(idle_slot),
    .mid_go(mid_go), .bit_q(bit_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         mode_q <= MD_NRZL;
    else if (idle_slot) mode_q <= mode_i;
  end

  assign tern = is_tern(mode_q);

  lenc_binary u_bin (
    .clk(clk), .rst_n(rst_n), .en(!tern), .mode(mode_q), .take(take),
    .in_bit(in_bit), .mid_go(mid_go), .lvl_q(lvl_q)
  );

  lenc_ternary u_ter (
    .clk(clk), .rst_n(rst_n), .en(tern), .mode(mode_q), .take(take),
    .idle_slot(idle_slot), .in_bit(in_bit), .code_q(tcode_q)
  );

  assign line_o = tern ? tcode_q : (lvl_q ? LC_HI : LC_LO);

  p_mode_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> $stable(mode_q));
  p_line_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(half_tick) |-> $stable(line_o));
  p_no_code10_r11: assert property (@(posedge clk) disable iff (!rst_n)
    line_o != 2'b10);
  p_binary_levels_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !is_tern(mode_q) |-> (line_o != LC_MID));
  p_man_mid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mid_go && mode_q == MD_MAN) |=> (line_o == (bit_q ? LC_LO : LC_HI)));
endmodule

// File: tb/tb_line_encoder.sv
`timescale 1ns/1ps
module tb_line_encoder;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       half_tick = 0;
  logic [2:0] mode_i = 0;
  logic       in_valid = 0;
  logic       in_bit = 0;
  logic       in_ready;
  logic [1:0] line_o;

  int checks = 0;
  int errors = 0;

  logic [1:0] exp_q[$];
  string      tag_q[$];
  logic       tick_d = 0;

  // model state
  logic [2:0] m_mode = 0;
  logic       m_lvl = 0;
  logic       m_pol = 0;

  always #2 clk = ~clk;

  line_encoder dut (
    .clk(clk), .rst_n(rst_n), .half_tick(half_tick), .mode_i(mode_i),
    .in_valid(in_valid), .in_ready(in_ready), .in_bit(in_bit), .line_o(line_o)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] lcode(input logic l);
    return l ? 2'b01 : 2'b11;
  endfunction

  always @(posedge clk) tick_d <= half_tick;

  // monitor: one result per tick, visible after the tick edge
  always @(negedge clk) begin
    if (tick_d && rst_n) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R11 unexpected tick result", line_o, 0);
      end else begin
        logic [1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(line_o == e, t, line_o, e);
      end
    end
  end

  task automatic slot(input logic v, input logic b, input logic [2:0] m);
    logic [1:0] e1, e2;
    string t;
    if (!v) begin
      m_mode = m;
      e1 = (m_mode == 4 || m_mode == 5) ? 2'b00 : lcode(m_lvl);
      e2 = e1;
      t = "R9 idle slot";
    end else begin
      case (m_mode)
        3'd1: begin m_lvl = m_lvl ^ b; e1 = lcode(m_lvl); e2 = e1; t = "R4 nrzi"; end
        3'd2: begin e1 = lcode(b); m_lvl = ~b; e2 = lcode(m_lvl); t = "R5 manchester"; end
        3'd3: begin
          logic f;
          f = b ? m_lvl : ~m_lvl;
          e1 = lcode(f); m_lvl = ~f; e2 = lcode(m_lvl); t = "R6 diff manchester";
        end
        3'd4, 3'd5: begin
          logic mk;
          mk = (m_mode == 4) ? b : ~b;
          if (mk) begin e1 = m_pol ? 2'b11 : 2'b01; m_pol = ~m_pol; end
          else e1 = 2'b00;
          e2 = e1;
          t = (m_mode == 4) ? "R7 ami" : "R8 pseudoternary";
        end
        default: begin m_lvl = b; e1 = lcode(b); e2 = e1; t = "R3 nrz-l"; end
      endcase
    end
    // start tick
    @(negedge clk);
    in_valid = v; in_bit = b; mode_i = m; half_tick = 1;
    exp_q.push_back(e1); tag_q.push_back({t, " first half"});
    #1 chk(in_ready == 1'b1, "R2 ready at start tick", in_ready, 1);
    @(negedge clk);
    half_tick = 0; in_valid = 0; in_bit = ~b;
    #1 chk(in_ready == 1'b0, "R2 ready without tick", in_ready, 0);
    @(negedge clk);
    // mid tick
    @(negedge clk);
    half_tick = 1; in_valid = 1;
    exp_q.push_back(e2); tag_q.push_back({t, " second half"});
    #1 chk(in_ready == 1'b0, "R2 ready at mid tick", in_ready, 0);
    @(negedge clk);
    half_tick = 0; in_valid = 0;
    @(negedge clk);
  endtask

  initial begin
    fork
      begin
        #400000;
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    join_none

    repeat (3) @(negedge clk);
    chk(line_o == 2'b11, "R1 line low in reset", line_o, 3);
    rst_n = 1;
    @(negedge clk);
    chk(line_o == 2'b11, "R1 line low after reset", line_o, 3);
    chk(in_ready == 1'b0, "R1 ready low after reset", in_ready, 0);

    // R3 NRZ-L from reset (mode stays 0)
    slot(1, 1, 0); slot(1, 0, 0); slot(1, 0, 0); slot(1, 1, 0);
    // R9 binary idle hold, R10 switch to NRZI
    slot(0, 0, 1);
    slot(1, 1, 1); slot(1, 1, 1); slot(1, 0, 1); slot(1, 1, 1); slot(1, 0, 1);
    // R4 then R5 Manchester; R10 mode_i changes during streaming are ignored
    slot(0, 0, 2);
    slot(1, 1, 4); slot(1, 0, 5); slot(1, 1, 0); slot(1, 1, 2); slot(1, 0, 3);
    // R6 differential Manchester
    slot(0, 0, 3);
    slot(1, 0, 3); slot(1, 0, 3); slot(1, 1, 3); slot(1, 0, 3); slot(1, 1, 1); slot(1, 1, 3);
    slot(0, 0, 3);
    // R7 AMI: first mark upper per R1
    slot(0, 0, 4);
    slot(1, 1, 4); slot(1, 0, 4); slot(1, 1, 4); slot(1, 1, 0); slot(1, 0, 4); slot(1, 1, 4);
    slot(0, 0, 4);
    // R8 pseudoternary, polarity continues
    slot(0, 0, 5);
    slot(1, 0, 5); slot(1, 1, 5); slot(1, 0, 5); slot(1, 0, 2);
    // R3 reserved mode 6 acts as NRZ-L, level restored from ternary
    slot(0, 0, 6);
    slot(1, 1, 6); slot(1, 0, 6); slot(1, 1, 6);
    slot(0, 0, 7);
    slot(1, 0, 7);

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R11 all ticks answered", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule